// File: doc/BRIEF.md
# Early Branch Target Generator

This block works out a predicted branch target in the fetch stage of a single-issue, five-stage pipeline on a 32-bit, word-addressed machine. It looks at the fetch PC and at the instruction word taken from a line-sized instruction buffer. From these it reports the kind of branch, whether a target is available, and the target word address. All of this happens combinationally, so the result is ready in the same cycle as the fetch.

There are two ways to form a target. A PC-relative branch uses a dedicated adder. The adder takes the PC and the sign-extended displacement, with the carry-in set, so the sum is the next sequential word plus the displacement. An indirect branch uses one of three shadow registers instead. Each shadow register snoops the register-file write port and keeps a copy of one fixed architectural register: the return register, the call register or the jump register. The selected copy gives the target. A write and a lookup of the same register in the same cycle are bypassed, so the lookup sees the new data.

Top module: `ftg_top`

## Requirements
- R1: Reset clears all three shadow registers to zero. An indirect lookup right after reset returns target 0 with `tgt_valid` high.
- R2: When instruction bits [31:30] are 2'b11, the instruction is PC-relative. `br_kind` is 3'd1, `tgt_valid` is 1, and `tgt_addr` = `fetch_pc` + 1 + sign_extend(instr[20:0]), taken modulo 2^32. This holds in the same cycle as the inputs.
- R3: The displacement is a signed 21-bit value. A negative displacement moves the target below the next sequential word. A sum that passes either end of the 32-bit space wraps around.
- R4: Opcode instr[31:26] = 6'h1A marks a jump-format instruction. With hint instr[15:14] = 2'b10 it is a return: `br_kind` is 3'd2 and the target is the shadow copy of register 26.
- R5: A jump-format instruction with hint 2'b01 is a call: `br_kind` is 3'd3 and the target is the shadow copy of register 27.
- R6: A jump-format instruction with hint 2'b00 is a plain jump: `br_kind` is 3'd4 and the target is the shadow copy of register 28.
- R7: A jump-format instruction with hint 2'b11 is the coroutine form. It gives `br_kind` 3'd0, `tgt_valid` 0 and `tgt_addr` 0.
- R8: Any other opcode gives `br_kind` 3'd0, `tgt_valid` 0 and `tgt_addr` 0.
- R9: A write with `rf_wr_en` high to index 26, 27 or 28 loads `rf_wr_data` into the matching shadow register at that clock edge. Lookups from the next cycle on return the new value.
- R10: A write with `rf_wr_en` low, or a write to any other index, leaves all three shadow registers unchanged.
- R11: When a write to register N and a lookup of register N happen in the same cycle, `tgt_addr` equals `rf_wr_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | 32 | Word address of the fetched instruction |
| fetch_instr | input | 32 | Instruction word from the instruction buffer |
| rf_wr_en | input | 1 | Register-file write enable (snooped) |
| rf_wr_idx | input | 5 | Register-file write index (snooped) |
| rf_wr_data | input | 32 | Register-file write data (snooped) |
| tgt_addr | output | 32 | Predicted target word address, 0 when not valid |
| tgt_valid | output | 1 | A target is available |
| br_kind | output | 3 | 0 none, 1 PC-relative, 2 return, 3 call, 4 jump |

## Verification
The only state in this block is the three shadow registers. Any error in them shows up at `tgt_addr` on the first indirect lookup of the affected register. Three kinds of error are possible: a lost write, a write landing in the wrong register, or a write to an unrelated index leaking in. Each shows one cycle after the write that caused it. Errors in the adder or the decoder have no delay at all: they show as a wrong target or a wrong kind in the same cycle as the instruction. For that reason the bench checks each result right after the edge that should have produced it.

// File: rtl/ftg_pkg.sv
package ftg_pkg;
   typedef enum logic [2:0] {
      BK_NONE  = 3'd0,
      BK_PCREL = 3'd1,
      BK_RET   = 3'd2,
      BK_CALL  = 3'd3,
      BK_JUMP  = 3'd4
   } br_kind_e;

   localparam int NUM_SHADOW = 3;
   localparam int SH_RET  = 0;
   localparam int SH_CALL = 1;
   localparam int SH_JUMP = 2;
endpackage

// File: rtl/ftg_decode.sv
module ftg_decode
   import ftg_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int DISP_W   = 21,
   parameter int JMP_OPC  = 6'h1A,
   parameter int HINT_LSB = 14
) (
   input  logic [XLEN-1:0]   instr,
   output br_kind_e          kind,
   output logic [DISP_W-1:0] disp
);
   localparam int OPC_LSB = XLEN - 6;

   logic [5:0] opcode;
   logic [1:0] hint;

   assign opcode = instr[XLEN-1:OPC_LSB];
   assign hint   = instr[HINT_LSB+1:HINT_LSB];
   assign disp   = instr[DISP_W-1:0];

   always_comb begin
      kind = BK_NONE;
      if (opcode[5:4] == 2'b11) begin
         kind = BK_PCREL;
      end else if (opcode == 6'(JMP_OPC)) begin
         unique case (hint)
            2'b00:   kind = BK_JUMP;
            2'b01:   kind = BK_CALL;
            2'b10:   kind = BK_RET;
            default: kind = BK_NONE;
         endcase
      end
   end
endmodule

// File: rtl/ftg_pcrel_adder.sv
module ftg_pcrel_adder #(
   parameter int XLEN   = 32,
   parameter int DISP_W = 21
) (
   input  logic [XLEN-1:0]   pc,
   input  logic [DISP_W-1:0] disp,
   output logic [XLEN-1:0]   target
);
   localparam int EXT_W = XLEN - DISP_W;

   logic [XLEN-1:0] disp_sx;
   logic [XLEN:0]   sum_ext;
   logic            unused_lsb;

   assign disp_sx = {{EXT_W{disp[DISP_W-1]}}, disp};
   // Appending a 1 to both operands makes a carry into bit 1 of one adder,
   // giving pc + disp + 1 with no separate increment.
   assign sum_ext    = {pc, 1'b1} + {disp_sx, 1'b1};
   assign target     = sum_ext[XLEN:1];
   assign unused_lsb = sum_ext[0];
endmodule

// File: rtl/ftg_shadow_bank.sv
module ftg_shadow_bank
   import ftg_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int IDX_W    = 5,
   parameter int RET_REG  = 26,
   parameter int CALL_REG = 27,
   parameter int JUMP_REG = 28,
   parameter bit FWD_EN   = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [IDX_W-1:0]      wr_idx,
   input  logic [XLEN-1:0]       wr_data,
   input  logic [1:0]            rd_sel,
   output logic [XLEN-1:0]       rd_data
);
   localparam logic [IDX_W-1:0] REG_MAP [NUM_SHADOW] =
      '{IDX_W'(RET_REG), IDX_W'(CALL_REG), IDX_W'(JUMP_REG)};

   logic [XLEN-1:0] shadow [NUM_SHADOW];
   logic [NUM_SHADOW-1:0] hit;

   for (genvar g = 0; g < NUM_SHADOW; g++) begin : g_shadow
      assign hit[g] = wr_en && (wr_idx == REG_MAP[g]);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      shadow[g] <= '0;
         else if (hit[g]) shadow[g] <= wr_data;
      end
   end

   logic [XLEN-1:0] stored;
   always_comb begin
      stored = '0;
      for (int i = 0; i < NUM_SHADOW; i++)
         if (rd_sel == 2'(i)) stored = shadow[i];
   end

   if (FWD_EN) begin : g_fwd
      logic sel_hit;
      always_comb begin
         sel_hit = 1'b0;
         for (int i = 0; i < NUM_SHADOW; i++)
            if (rd_sel == 2'(i) && hit[i]) sel_hit = 1'b1;
      end
      assign rd_data = sel_hit ? wr_data : stored;
   end else begin : g_nofwd
      assign rd_data = stored;
   end
endmodule

// File: rtl/ftg_top.sv
module ftg_top
   import ftg_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int DISP_W   = 21,
   parameter int IDX_W    = 5,
   parameter int RET_REG  = 26,
   parameter int CALL_REG = 27,
   parameter int JUMP_REG = 28,
   parameter int JMP_OPC  = 6'h1A,
   parameter int HINT_LSB = 14,
   parameter bit FWD_EN   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [31:0]      fetch_pc,
   input  logic [31:0]      fetch_instr,
   input  logic             rf_wr_en,
   input  logic [4:0]       rf_wr_idx,
   input  logic [31:0]      rf_wr_data,
   output logic [31:0]      tgt_addr,
   output logic             tgt_valid,
   output logic [2:0]       br_kind
);
   if (XLEN != 32 || IDX_W != 5) begin : g_chk_port
      $error("ftg_top: port widths assume XLEN=32, IDX_W=5");
   end
   if (DISP_W < 2 || DISP_W >= XLEN) begin : g_chk_disp
      $error("ftg_top: DISP_W out of range");
   end
   if (HINT_LSB + 1 >= XLEN - 6) begin : g_chk_hint
      $error("ftg_top: hint field overlaps opcode");
   end
   if (RET_REG == CALL_REG || RET_REG == JUMP_REG || CALL_REG == JUMP_REG) begin : g_chk_regs
      $error("ftg_top: shadowed registers must differ");
   end
   if (RET_REG >= (1 << IDX_W) || CALL_REG >= (1 << IDX_W) || JUMP_REG >= (1 << IDX_W)) begin : g_chk_idx
      $error("ftg_top: register index exceeds IDX_W");
   end

   br_kind_e          kind;
   logic [DISP_W-1:0] disp;
   logic [XLEN-1:0]   rel_tgt;
   logic [XLEN-1:0]   ind_tgt;
   logic [1:0]        rd_sel;

   ftg_decode #(.XLEN(XLEN), .DISP_W(DISP_W), .JMP_OPC(JMP_OPC), .HINT_LSB(HINT_LSB)) u_dec (
      .instr (fetch_instr),
      .kind  (kind),
      .disp  (disp)
   );

   ftg_pcrel_adder #(.XLEN(XLEN), .DISP_W(DISP_W)) u_add (
      .pc     (fetch_pc),
      .disp   (disp),
      .target (rel_tgt)
   );

   always_comb begin
      unique case (kind)
         BK_CALL: rd_sel = 2'(SH_CALL);
         BK_JUMP: rd_sel = 2'(SH_JUMP);
         default: rd_sel = 2'(SH_RET);
      endcase
   end

   ftg_shadow_bank #(
      .XLEN(XLEN), .IDX_W(IDX_W), .RET_REG(RET_REG), .CALL_REG(CALL_REG),
      .JUMP_REG(JUMP_REG), .FWD_EN(FWD_EN)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (rf_wr_en),
      .wr_idx  (rf_wr_idx),
      .wr_data (rf_wr_data),
      .rd_sel  (rd_sel),
      .rd_data (ind_tgt)
   );

   always_comb begin
      unique case (kind)
         BK_PCREL:                 tgt_addr = rel_tgt;
         BK_RET, BK_CALL, BK_JUMP: tgt_addr = ind_tgt;
         default:                  tgt_addr = '0;
      endcase
   end

   assign tgt_valid = (kind != BK_NONE);
   assign br_kind   = kind;
endmodule

// File: rtl/ftg_checker.sv
module ftg_checker #(
   parameter int DISP_W   = 21,
   parameter int RET_REG  = 26,
   parameter int CALL_REG = 27,
   parameter int JMP_OPC  = 6'h1A,
   parameter int HINT_LSB = 14,
   parameter bit FWD_EN   = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic [31:0] fetch_pc,
   input logic [31:0] fetch_instr,
   input logic        rf_wr_en,
   input logic [4:0]  rf_wr_idx,
   input logic [31:0] rf_wr_data,
   input logic [31:0] tgt_addr,
   input logic        tgt_valid,
   input logic [2:0]  br_kind
);
   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   logic [31:0] exp_rel;
   logic        ret_wr;
   assign exp_rel = fetch_pc + 32'(signed'(fetch_instr[DISP_W-1:0])) + 32'd1;
   assign ret_wr  = rf_wr_en && (rf_wr_idx == 5'(RET_REG));

   AST_IDLE_TARGET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !tgt_valid |-> (tgt_addr == 32'd0 && br_kind == 3'd0)) else $error("idle target"); // R8

   AST_CORO_NO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_instr[31:26] == 6'(JMP_OPC) && fetch_instr[HINT_LSB+1:HINT_LSB] == 2'b11)
      |-> !tgt_valid) else $error("coroutine valid"); // R7

   AST_PCREL_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      (br_kind == 3'd1) |-> (tgt_addr == exp_rel && fetch_instr[31:30] == 2'b11))
      else $error("pcrel sum"); // R2

   AST_RET_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && br_kind == 3'd2 && !ret_wr && $past(ret_wr)) |-> (tgt_addr == $past(rf_wr_data)))
      else $error("ret capture"); // R9

   AST_CALL_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
      (FWD_EN && br_kind == 3'd3 && rf_wr_en && rf_wr_idx == 5'(CALL_REG)) |-> (tgt_addr == rf_wr_data))
      else $error("call forward"); // R11
endmodule

bind ftg_top ftg_checker #(
   .DISP_W(DISP_W), .RET_REG(RET_REG), .CALL_REG(CALL_REG),
   .JMP_OPC(JMP_OPC), .HINT_LSB(HINT_LSB), .FWD_EN(FWD_EN)
) u_chk (.*);

// File: tb/ftg_top_tb.sv
`timescale 1ns/1ps
module ftg_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] fetch_pc = '0;
   logic [31:0] fetch_instr = '0;
   logic        rf_wr_en = 1'b0;
   logic [4:0]  rf_wr_idx = '0;
   logic [31:0] rf_wr_data = '0;
   logic [31:0] tgt_addr;
   logic        tgt_valid;
   logic [2:0]  br_kind;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;
   logic [31:0] sh [3];   // bench model: 0 ret(26), 1 call(27), 2 jump(28)

   always #2.5 clk = ~clk;

   ftg_top u_dut (.*);

   function automatic logic [31:0] mk_rel(input logic [5:0] opc, input logic [20:0] d);
      return {opc, 5'd3, d};
   endfunction
   function automatic logic [31:0] mk_jmp(input logic [1:0] h);
      return {6'h1A, 10'h155, h, 14'h0ABC};
   endfunction

   task automatic check(input string req, input logic [31:0] a_t, input logic a_v,
                        input logic [2:0] a_k, input logic [31:0] e_t, input logic e_v,
                        input logic [2:0] e_k);
      n_run++;
      if (a_t !== e_t || a_v !== e_v || a_k !== e_k) begin
         n_fail++;
         $display("FAIL %s: got tgt=%h v=%0b k=%0d exp tgt=%h v=%0b k=%0d",
                  req, a_t, a_v, a_k, e_t, e_v, e_k);
      end
   endtask

   // Drive at negedge, sample 1 ns later (outputs are combinational).
   task automatic look(input string req, input logic [31:0] pc, input logic [31:0] ins,
                       input logic [31:0] e_t, input logic e_v, input logic [2:0] e_k);
      @(negedge clk);
      fetch_pc = pc; fetch_instr = ins; rf_wr_en = 1'b0;
      #1 check(req, tgt_addr, tgt_valid, br_kind, e_t, e_v, e_k);
   endtask

   task automatic wr(input logic en, input logic [4:0] idx, input logic [31:0] d);
      @(negedge clk);
      fetch_instr = 32'h0; rf_wr_en = en; rf_wr_idx = idx; rf_wr_data = d;
      @(posedge clk);
      if (en && idx >= 5'd26 && idx <= 5'd28) sh[idx - 5'd26] = d;
   endtask

   task automatic t_reset;
      look("R1", 32'h10, mk_jmp(2'b10), 32'h0, 1'b1, 3'd2);
      look("R1", 32'h10, mk_jmp(2'b01), 32'h0, 1'b1, 3'd3);
      look("R1", 32'h10, mk_jmp(2'b00), 32'h0, 1'b1, 3'd4);
   endtask

   task automatic t_pcrel;
      look("R2", 32'h0000_1000, mk_rel(6'h30, 21'h10), 32'h0000_1011, 1'b1, 3'd1);
      look("R2", 32'h1234_0000, mk_rel(6'h3F, 21'h0), 32'h1234_0001, 1'b1, 3'd1);
      look("R2", 32'h0000_0010, mk_rel(6'h38, 21'h0F_FFFF), 32'h0010_0010, 1'b1, 3'd1);
   endtask

   task automatic t_pcrel_neg;
      look("R3", 32'd100, mk_rel(6'h31, 21'h1F_FFFB), 32'd96, 1'b1, 3'd1);
      look("R3", 32'h0, mk_rel(6'h31, 21'h1F_FFFF), 32'h0, 1'b1, 3'd1);
      look("R3", 32'hFFFF_FFFF, mk_rel(6'h31, 21'h0), 32'h0, 1'b1, 3'd1);
      look("R3", 32'h0000_0005, mk_rel(6'h33, 21'h10_0000), 32'hFFF0_0006, 1'b1, 3'd1);
   endtask

   task automatic t_indirect;
      wr(1'b1, 5'd26, 32'hAAAA_0026);
      look("R9", 32'h0, mk_jmp(2'b10), 32'hAAAA_0026, 1'b1, 3'd2);
      wr(1'b1, 5'd27, 32'hBBBB_0027);
      wr(1'b1, 5'd28, 32'hCCCC_0028);
      look("R4", 32'h0, mk_jmp(2'b10), 32'hAAAA_0026, 1'b1, 3'd2);
      look("R5", 32'h0, mk_jmp(2'b01), 32'hBBBB_0027, 1'b1, 3'd3);
      look("R6", 32'h0, mk_jmp(2'b00), 32'hCCCC_0028, 1'b1, 3'd4);
   endtask

   task automatic t_ignored;
      wr(1'b0, 5'd26, 32'hDEAD_0000);
      wr(1'b1, 5'd25, 32'hDEAD_0025);
      wr(1'b1, 5'd29, 32'hDEAD_0029);
      wr(1'b1, 5'd10, 32'hDEAD_0010);
      look("R10", 32'h0, mk_jmp(2'b10), sh[0], 1'b1, 3'd2);
      look("R10", 32'h0, mk_jmp(2'b01), sh[1], 1'b1, 3'd3);
      look("R10", 32'h0, mk_jmp(2'b00), sh[2], 1'b1, 3'd4);
   endtask

   task automatic t_none;
      look("R7", 32'h40, mk_jmp(2'b11), 32'h0, 1'b0, 3'd0);
      look("R8", 32'h40, 32'h0000_0000, 32'h0, 1'b0, 3'd0);
      look("R8", 32'h40, {6'h1B, 26'h000_4000}, 32'h0, 1'b0, 3'd0);
      look("R8", 32'h40, {6'h2F, 26'h3FF_FFFF}, 32'h0, 1'b0, 3'd0);
   endtask

   task automatic t_forward;
      for (int k = 0; k < 3; k++) begin
         logic [31:0] d;
         logic [1:0]  h;
         d = 32'h5000_0000 + 32'(k);
         h = (k == 0) ? 2'b10 : (k == 1) ? 2'b01 : 2'b00;
         @(negedge clk);
         fetch_instr = mk_jmp(h); rf_wr_en = 1'b1;
         rf_wr_idx = 5'(26 + k); rf_wr_data = d;
         #1 check("R11", tgt_addr, tgt_valid, br_kind, d, 1'b1, 3'(2 + k));
         @(posedge clk);
         sh[k] = d;
      end
      look("R9", 32'h0, mk_jmp(2'b01), 32'h5000_0001, 1'b1, 3'd3);
   endtask

   task automatic t_sweep;
      for (int i = 0; i < 300; i++) begin
         logic [31:0] pc, ins, d, e_t;
         logic [4:0]  idx;
         logic        en, e_v;
         logic [2:0]  e_k;
         int          sel;
         pc = $urandom; d = $urandom;
         idx = 5'(24 + ($urandom % 7)); en = 1'($urandom);
         sel = $urandom % 3;
         if (sel == 0) ins = mk_rel(6'h30 | 6'($urandom % 16), 21'($urandom));
         else if (sel == 1) ins = mk_jmp(2'($urandom));
         else ins = {6'($urandom % 48), 26'($urandom)};
         e_t = 32'h0; e_v = 1'b0; e_k = 3'd0;
         if (ins[31:30] == 2'b11) begin
            e_k = 3'd1; e_v = 1'b1;
            e_t = pc + {{11{ins[20]}}, ins[20:0]} + 32'd1;
         end else if (ins[31:26] == 6'h1A && ins[15:14] != 2'b11) begin
            int r;
            r = (ins[15:14] == 2'b10) ? 0 : (ins[15:14] == 2'b01) ? 1 : 2;
            e_k = 3'(2 + r); e_v = 1'b1;
            e_t = (en && idx == 5'(26 + r)) ? d : sh[r];
         end
         @(negedge clk);
         fetch_pc = pc; fetch_instr = ins; rf_wr_en = en; rf_wr_idx = idx; rf_wr_data = d;
         #1 check("R2/R4/R9 sweep", tgt_addr, tgt_valid, br_kind, e_t, e_v, e_k);
         @(posedge clk);
         if (en && idx >= 5'd26 && idx <= 5'd28) sh[idx - 5'd26] = d;
      end
   endtask

   initial begin
      sh[0] = '0; sh[1] = '0; sh[2] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_pcrel();
      t_pcrel_neg();
      t_indirect();
      t_ignored();
      t_none();
      t_forward();
      t_sweep();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: got running exp finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule